// File: doc/BRIEF.md
# Digital AGC Loop Controller

This block closes the digital side of an automatic gain control loop for an I/Q receiver. Once per update period it takes the current decimated I and Q samples and forms a magnitude estimate |I| + |Q|. It converts the estimate to a logarithmic code in half-octave (about 3 dB) steps and compares it with a target a chosen number of half-octaves below the clip code. The result moves a saturating gain integrator. Gain falls quickly when the signal is too strong (attack). Gain rises more slowly when the signal is too weak (decay).

An overload flag from an analog comparator takes priority over the estimate while it is high. Each update with the flag high pulls the gain down by a power-of-two weight. The top bits of the integrator drive an 8-bit gain DAC. At the end of every report interval the block publishes the number of overloaded updates and the gain code.

Settings come from one 16-bit control word, loaded through a byte-wide write port. When the reference field is zero the loop is off, and the DAC code is taken straight from the control word.

Top module: `agc_loop_ctrl`

## Requirements
- R1: The control word is loaded through byte writes. A write with `wr_hi`=0 only stages `wr_data`. A write with `wr_hi`=1 loads the whole word at once as {wr_data, staged byte}. Nothing else changes the word. Field layout: bit 15 is the preamp attenuation, [14:12] the reference, [11:8] the attack code, [7:4] the decay code, [3:0] the overload weight, and [7:0] the manual gain code.
- R2: With reference 0 (manual mode), `dac_code` equals the control word's bits [7:0] one clock after they are loaded. The integrator is preset to that code with its low bits zero, so the loop resumes from it. After reset the word is 0, so `dac_code` is 0.
- R3: In automatic mode the gain updates once every DEC=20 clocks, counted from reset. `upd_strobe` is high for the one clock after each update, and `dac_code`, `rpt_valid`, `rpt_ovl` and `rpt_gain` are valid in that clock.
- R4: The estimate is |I| + |Q| of the samples present at the update edge. Its log code is 2p + f. Here p is the index of the highest set bit (taken as 0 below 2), and f is the bit just below it.
- R5: The target log code is 24 - r, where r is the reference field. Values 6 and 7 act as 5.
- R6: If the log code exceeds the target, the integrator falls by k(attack) × min(|error|, 15), where k(c) = ((c odd ? 181 : 128) << (c >> 1)) >> 4.
- R7: If the log code is below the target, the integrator rises by k(d) × min(error, 15), where d = attack − decay, or 0 when decay exceeds attack.
- R8: If `ovl_in` is high at an update, the integrator falls by 2^w (w = overload weight), whatever the estimate.
- R9: The 16-bit integrator saturates at 0 and at 65535 and never wraps. `dac_code` is its upper 8 bits.
- R10: Every fourth update, counted from reset, ends a report interval. `rpt_valid` then pulses, `rpt_ovl` gives the number of updates in that interval with `ovl_in` high, and `rpt_gain` gives the new `dac_code`. At all other strobes `rpt_valid` is 0.
- R11: `preamp_att` follows bit 15 of the loaded control word.
- R12: In automatic mode the integrator does not change between updates. A log code equal to the target leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_hi | input | 1 | 0 stages the low byte, 1 loads the whole word |
| wr_data | input | 8 | Write byte |
| smp_i | input | SMP_W | Signed decimated I sample |
| smp_q | input | SMP_W | Signed decimated Q sample |
| ovl_in | input | 1 | Analog overload comparator flag |
| dac_code | output | DAC_W | Gain DAC code |
| preamp_att | output | 1 | Fixed preamp attenuation enable |
| upd_strobe | output | 1 | One-clock pulse after each gain update |
| rpt_valid | output | 1 | End of report interval |
| rpt_ovl | output | clog2(OUT_UPD+1) | Overloaded updates in the interval |
| rpt_gain | output | DAC_W | Gain code at the end of the interval |

## Verification
The assertions check on every cycle the direction of each update: overload always lowers a nonzero gain, a strong estimate never raises the gain, and a weak one never lowers it. They also check that gain holds between updates, that manual mode follows the control word, that a staged byte alone leaves the word untouched, and that reports coincide with strobes. Only the bench scenarios show exact step sizes, including the half-octave code scaling, the clamp of the error, the reference values above 5 and the two saturation limits. The same holds for the exact overload counts over a report interval, since these depend on arithmetic over several updates.

// File: rtl/agc_pkg.sv
package agc_pkg;

  typedef struct packed {
    logic       preamp;
    logic [2:0] ref_lvl;
    logic [3:0] attack;
    logic [3:0] decay;
    logic [3:0] ovl_wt;
  } agc_cfg_t;

  localparam int REF_MAX = 5;
  localparam int K_FRAC  = 4;
  localparam int K_ROOT2 = 181;
  localparam int K_UNIT  = 128;

  // step gain for a half-octave code: base (1 or sqrt2) times 2^(code/2)
  function automatic logic [15:0] half_oct_k(input logic [3:0] code);
    logic [15:0] base;
    base = code[0] ? 16'(K_ROOT2) : 16'(K_UNIT);
    return (base << code[3:1]) >> K_FRAC;
  endfunction

endpackage

// File: rtl/agc_cfg_regs.sv
module agc_cfg_regs
  import agc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_hi,
  input  logic [7:0] wr_data,
  output agc_cfg_t   cfg
);

  logic [7:0] lo_stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_stage <= '0;
      cfg      <= '0;
    end else if (wr_en) begin
      if (wr_hi) cfg <= agc_cfg_t'({wr_data, lo_stage});
      else       lo_stage <= wr_data;
    end
  end

  assert_word_held_R1: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_hi) |=> $stable(cfg));

endmodule

// File: rtl/agc_mag_log.sv
module agc_mag_log #(
  parameter int SMP_W = 12,
  parameter int EW    = SMP_W + 1,
  parameter int LG_W  = $clog2(2 * EW)
) (
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic signed [SMP_W-1:0] smp_q,
  output logic        [LG_W-1:0]  lg
);

  logic signed [SMP_W-1:0] chan [2];
  logic        [EW-1:0]    mag  [2];
  logic        [EW-1:0]    est;
  logic        [LG_W-1:0]  pos;
  logic                    frac;

  assign chan[0] = smp_i;
  assign chan[1] = smp_q;

  for (genvar ch = 0; ch < 2; ch++) begin : g_abs
    logic signed [EW-1:0] ext;
    assign ext     = EW'(chan[ch]);
    assign mag[ch] = ext[EW-1] ? EW'(-ext) : EW'(ext);
  end

  assign est = mag[0] + mag[1];

  always_comb begin
    pos  = '0;
    frac = 1'b0;
    for (int b = 1; b < EW; b++) begin
      if (est[b]) begin
        pos  = LG_W'(b);
        frac = est[b-1];
      end
    end
    lg = (pos << 1) + LG_W'(frac);
  end

endmodule

// File: rtl/agc_step_calc.sv
module agc_step_calc
  import agc_pkg::*;
#(
  parameter int EW    = 13,
  parameter int LG_W  = 5,
  parameter int INT_W = 16,
  parameter int EMAX  = 15,
  parameter int DW    = INT_W + 2
) (
  input  logic [2:0]          ref_lvl,
  input  logic [3:0]          attack,
  input  logic [3:0]          decay,
  input  logic [3:0]          ovl_wt,
  input  logic                ovl,
  input  logic [LG_W-1:0]     lg,
  output logic [LG_W-1:0]     target,
  output logic signed [DW-1:0] delta
);

  localparam int CLIP_LG = 2 * (EW - 1);
  localparam int EMAX_W  = $clog2(EMAX + 1);
  localparam int PW      = 16 + EMAX_W;

  logic [2:0]          ref_eff;
  logic signed [LG_W:0] err;
  logic [LG_W:0]       abs_err;
  logic [EMAX_W-1:0]   emag;
  logic [3:0]          dcode;
  logic [PW-1:0]       prod_att, prod_dec;

  always_comb begin
    ref_eff  = (ref_lvl > 3'(REF_MAX)) ? 3'(REF_MAX) : ref_lvl;
    target   = LG_W'(CLIP_LG) - LG_W'(ref_eff);
    err      = $signed({1'b0, target}) - $signed({1'b0, lg});
    abs_err  = err[LG_W] ? unsigned'(-err) : unsigned'(err);
    emag     = (abs_err > (LG_W+1)'(EMAX)) ? EMAX_W'(EMAX) : abs_err[EMAX_W-1:0];
    dcode    = (attack >= decay) ? (attack - decay) : 4'd0;
    prod_att = PW'(half_oct_k(attack)) * PW'(emag);
    prod_dec = PW'(half_oct_k(dcode)) * PW'(emag);
    if (ovl)
      delta = -$signed(DW'(1) << ovl_wt);
    else if (err < 0)
      delta = -$signed(DW'(prod_att));
    else if (err > 0)
      delta = $signed(DW'(prod_dec));
    else
      delta = '0;
  end

endmodule

// File: rtl/agc_gain_integ.sv
module agc_gain_integ #(
  parameter int INT_W = 16,
  parameter int DAC_W = 8,
  parameter int DW    = INT_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 auto_on,
  input  logic [DAC_W-1:0]     man_gain,
  input  logic signed [DW-1:0] delta,
  output logic [INT_W-1:0]     integ,
  output logic [DAC_W-1:0]     gain_nx
);

  localparam logic signed [DW-1:0] TOP = $signed({2'b00, {INT_W{1'b1}}});

  logic signed [DW-1:0] sum;
  logic [INT_W-1:0]     sat;
  logic [INT_W-1:0]     nxt;

  always_comb begin
    sum = $signed({2'b00, integ}) + delta;
    if (sum < 0)        sat = '0;
    else if (sum > TOP) sat = '1;
    else                sat = sum[INT_W-1:0];
    if (!auto_on)       nxt = {man_gain, {(INT_W-DAC_W){1'b0}}};
    else if (tick)      nxt = sat;
    else                nxt = integ;
  end

  assign gain_nx = nxt[INT_W-1 -: DAC_W];

  always_ff @(posedge clk) begin
    if (rst) integ <= '0;
    else     integ <= nxt;
  end

  assert_manual_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !auto_on |=> integ == {$past(man_gain), {(INT_W-DAC_W){1'b0}}});

  assert_hold_between_R12: assert property (@(posedge clk) disable iff (rst)
    (auto_on && !tick) |=> $stable(integ));

endmodule

// File: rtl/agc_ovl_report.sv
module agc_ovl_report #(
  parameter int OUT_UPD = 4,
  parameter int DAC_W   = 8,
  parameter int CNT_W   = $clog2(OUT_UPD + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ovl,
  input  logic [DAC_W-1:0] gain_nx,
  output logic             rpt_valid,
  output logic [CNT_W-1:0] rpt_ovl,
  output logic [DAC_W-1:0] rpt_gain
);

  localparam int IW = (OUT_UPD > 1) ? $clog2(OUT_UPD) : 1;

  logic [IW-1:0]    idx;
  logic [CNT_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      acc       <= '0;
      rpt_valid <= 1'b0;
      rpt_ovl   <= '0;
      rpt_gain  <= '0;
    end else begin
      rpt_valid <= 1'b0;
      if (tick) begin
        if (idx == IW'(OUT_UPD - 1)) begin
          idx       <= '0;
          acc       <= '0;
          rpt_valid <= 1'b1;
          rpt_ovl   <= acc + CNT_W'(ovl);
          rpt_gain  <= gain_nx;
        end else begin
          idx <= idx + 1'b1;
          acc <= acc + CNT_W'(ovl);
        end
      end
    end
  end

endmodule

// File: rtl/agc_loop_ctrl.sv
module agc_loop_ctrl
  import agc_pkg::*;
#(
  parameter int SMP_W   = 12,
  parameter int DEC     = 20,
  parameter int INT_W   = 16,
  parameter int DAC_W   = 8,
  parameter int OUT_UPD = 4,
  parameter int EMAX    = 15
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          wr_hi,
  input  logic [7:0]                    wr_data,
  input  logic signed [SMP_W-1:0]       smp_i,
  input  logic signed [SMP_W-1:0]       smp_q,
  input  logic                          ovl_in,
  output logic [DAC_W-1:0]              dac_code,
  output logic                          preamp_att,
  output logic                          upd_strobe,
  output logic                          rpt_valid,
  output logic [$clog2(OUT_UPD+1)-1:0]  rpt_ovl,
  output logic [DAC_W-1:0]              rpt_gain
);

  localparam int EW    = SMP_W + 1;
  localparam int LG_W  = $clog2(2 * EW);
  localparam int DW    = INT_W + 2;
  localparam int TW    = $clog2(DEC);
  localparam int CNT_W = $clog2(OUT_UPD + 1);

  agc_cfg_t             cfg;
  logic [TW-1:0]        cnt;
  logic                 tick;
  logic                 auto_on;
  logic [LG_W-1:0]      lg;
  logic [LG_W-1:0]      target;
  logic signed [DW-1:0] delta;
  logic [INT_W-1:0]     integ;
  logic [DAC_W-1:0]     gain_nx;

  agc_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_hi(wr_hi),
    .wr_data(wr_data), .cfg(cfg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      upd_strobe <= 1'b0;
    end else begin
      cnt        <= tick ? '0 : cnt + 1'b1;
      upd_strobe <= tick;
    end
  end

  assign tick    = (cnt == TW'(DEC - 1));
  assign auto_on = (cfg.ref_lvl != 3'd0);

  agc_mag_log #(.SMP_W(SMP_W), .EW(EW), .LG_W(LG_W)) u_mag (
    .smp_i(smp_i), .smp_q(smp_q), .lg(lg)
  );

  agc_step_calc #(.EW(EW), .LG_W(LG_W), .INT_W(INT_W), .EMAX(EMAX), .DW(DW)) u_step (
    .ref_lvl(cfg.ref_lvl), .attack(cfg.attack), .decay(cfg.decay),
    .ovl_wt(cfg.ovl_wt), .ovl(ovl_in), .lg(lg), .target(target), .delta(delta)
  );

  agc_gain_integ #(.INT_W(INT_W), .DAC_W(DAC_W), .DW(DW)) u_integ (
    .clk(clk), .rst(rst), .tick(tick), .auto_on(auto_on),
    .man_gain(DAC_W'({cfg.decay, cfg.ovl_wt})), .delta(delta),
    .integ(integ), .gain_nx(gain_nx)
  );

  agc_ovl_report #(.OUT_UPD(OUT_UPD), .DAC_W(DAC_W), .CNT_W(CNT_W)) u_rpt (
    .clk(clk), .rst(rst), .tick(tick), .ovl(ovl_in), .gain_nx(gain_nx),
    .rpt_valid(rpt_valid), .rpt_ovl(rpt_ovl), .rpt_gain(rpt_gain)
  );

  assign dac_code   = integ[INT_W-1 -: DAC_W];
  assign preamp_att = cfg.preamp;

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |=> !upd_strobe);

  assert_report_on_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |-> upd_strobe);

  assert_overload_lowers_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && auto_on && ovl_in && integ != '0) |=> integ < $past(integ));

  assert_strong_no_rise_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && auto_on && !ovl_in && lg > target) |=> integ <= $past(integ));

  assert_weak_no_fall_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && auto_on && !ovl_in && lg < target) |=> integ >= $past(integ));

endmodule

// File: tb/agc_loop_ctrl_bench.sv
`timescale 1ns/1ps
module agc_loop_ctrl_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst, wr_en, wr_hi, ovl_in;
  logic [7:0]        wr_data;
  logic signed [11:0] smp_i, smp_q;
  logic [7:0]        dac_code, rpt_gain;
  logic              preamp_att, upd_strobe, rpt_valid;
  logic [2:0]        rpt_ovl;

  agc_loop_ctrl u_agc_loop_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
    .smp_i(smp_i), .smp_q(smp_q), .ovl_in(ovl_in), .dac_code(dac_code),
    .preamp_att(preamp_att), .upd_strobe(upd_strobe), .rpt_valid(rpt_valid),
    .rpt_ovl(rpt_ovl), .rpt_gain(rpt_gain)
  );

  int total = 0, bad = 0;
  longint cyc = 0, last_strobe = -1;
  int m_integ = 0, m_idx = 0, m_acc = 0;
  logic [15:0] m_cfg = '0;
  logic [7:0]  m_lo = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic int log_code(input int est);
    int p = 0, f = 0;
    for (int b = 1; b < 13; b++)
      if (est[b]) begin p = b; f = est[b-1]; end
    return 2 * p + f;
  endfunction

  function automatic int k_of(input int c);
    return ((((c & 1) != 0) ? 181 : 128) << (c >> 1)) >> 4;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic wr_byte(input bit hi, input logic [7:0] d);
    wr_en = 1'b1; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (hi) m_cfg = {d, m_lo};
    else    m_lo  = d;
  endtask

  task automatic wait_strobe();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!upd_strobe && n < 200);
    if (!upd_strobe) begin
      check(1'b0, "R3", "strobe timeout", n, 20);
      finish_run();
    end
    if (last_strobe >= 0)
      check(cyc - last_strobe == 20, "R3", "update period", int'(cyc - last_strobe), 20);
    last_strobe = cyc;
  endtask

  task automatic do_update(input int iv, input int qv, input bit ov, input string req);
    int r, tgt, e, emag, dcd, att, dec, wt;
    smp_i = 12'(iv); smp_q = 12'(qv); ovl_in = ov;
    wait_strobe();
    r   = int'(m_cfg[14:12]);
    att = int'(m_cfg[11:8]);
    dec = int'(m_cfg[7:4]);
    wt  = int'(m_cfg[3:0]);
    if (r == 0) begin
      m_integ = int'(m_cfg[7:0]) << 8;
    end else begin
      if (r > 5) r = 5;
      tgt  = 24 - r;
      e    = tgt - log_code(iabs(iv) + iabs(qv));
      emag = (iabs(e) > 15) ? 15 : iabs(e);
      dcd  = (att >= dec) ? att - dec : 0;
      if (ov)         m_integ -= (1 << wt);
      else if (e < 0) m_integ -= k_of(att) * emag;
      else if (e > 0) m_integ += k_of(dcd) * emag;
      if (m_integ < 0)     m_integ = 0;
      if (m_integ > 65535) m_integ = 65535;
    end
    check(dac_code == 8'(m_integ >> 8), req, "dac_code", int'(dac_code), m_integ >> 8);
    m_acc += int'(ov);
    if (m_idx == 3) begin
      check(rpt_valid == 1'b1, "R10", "rpt_valid at interval end", int'(rpt_valid), 1);
      check(int'(rpt_ovl) == m_acc, "R10", "rpt_ovl", int'(rpt_ovl), m_acc);
      check(rpt_gain == 8'(m_integ >> 8), "R10", "rpt_gain", int'(rpt_gain), m_integ >> 8);
      m_acc = 0; m_idx = 0;
    end else begin
      check(rpt_valid == 1'b0, "R10", "rpt_valid mid interval", int'(rpt_valid), 0);
      m_idx++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R3", "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; wr_en = 1'b0; wr_hi = 1'b0; wr_data = '0;
    smp_i = '0; smp_q = '0; ovl_in = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check(dac_code == 8'd0, "R2", "reset dac_code", int'(dac_code), 0);
    check(preamp_att == 1'b0, "R11", "reset preamp", int'(preamp_att), 0);
    check(rpt_valid == 1'b0, "R10", "reset rpt_valid", int'(rpt_valid), 0);
    do_update(0, 0, 0, "R2");

    // manual mode with preamp attenuation on
    wr_byte(1'b0, 8'hA5);
    wr_byte(1'b1, 8'h80);
    @(negedge clk);
    check(dac_code == 8'hA5, "R2", "manual dac_code", int'(dac_code), 'hA5);
    check(preamp_att == 1'b1, "R11", "preamp set", int'(preamp_att), 1);
    do_update(100, -50, 0, "R2");

    // staged byte alone must not change the word
    wr_byte(1'b0, 8'h11);
    @(negedge clk);
    check(dac_code == 8'hA5, "R1", "staged byte no effect", int'(dac_code), 'hA5);
    check(preamp_att == 1'b1, "R1", "staged byte preamp", int'(preamp_att), 1);
    do_update(0, 0, 0, "R1");

    // auto: ref 2, attack 4, decay 1, weight 1
    wr_byte(1'b1, 8'h24);
    check(preamp_att == 1'b0, "R11", "preamp cleared", int'(preamp_att), 0);
    repeat (3) do_update(0, 0, 0, "R7");
    repeat (3) do_update(2047, 2047, 0, "R6");
    repeat (2) do_update(-2048, 0, 0, "R12");
    do_update(-1024, -1024, 0, "R4");
    do_update(300, -200, 0, "R4");

    // ref 7 acts as 5: log code 19 is on target
    wr_byte(1'b1, 8'h74);
    repeat (2) do_update(768, 0, 0, "R5");
    do_update(1500, 0, 0, "R5");

    // overload wins over a weak signal
    repeat (2) do_update(0, 0, 1, "R8");

    // floor saturation with heaviest overload weight
    wr_byte(1'b0, 8'h1F);
    wr_byte(1'b1, 8'h24);
    repeat (3) do_update(0, 0, 1, "R9");
    check(dac_code == 8'd0, "R9", "floor", int'(dac_code), 0);

    // ceiling saturation from a manual preset
    wr_byte(1'b0, 8'hFF);
    wr_byte(1'b1, 8'h00);
    do_update(0, 0, 0, "R2");
    wr_byte(1'b0, 8'h00);
    wr_byte(1'b1, 8'h1F);
    repeat (2) do_update(0, 0, 0, "R9");
    check(dac_code == 8'hFF, "R9", "ceiling", int'(dac_code), 'hFF);

    // constrained random
    for (int n = 0; n < 200; n++) begin
      int iv, qv, sh;
      bit ov;
      if (n % 10 == 0) begin
        wr_byte(1'b0, 8'($urandom));
        wr_byte(1'b1, {1'($urandom), 3'($urandom % 8), 4'($urandom)});
      end
      sh = int'($urandom % 12);
      iv = (int'($urandom % 4096) - 2048) >>> sh;
      qv = (int'($urandom % 4096) - 2048) >>> sh;
      ov = (($urandom % 8) == 0);
      do_update(iv, qv, ov, "R6");
    end

    finish_run();
  end

endmodule